// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

The block holds two 16-bit timer/counters, each built from a low count byte and a high count byte. Each timer advances either on a shared time base or on falling edges of its own event input. The time base produces one tick for every six clock cycles. A configuration byte gives each timer a gate enable, a counter/timer select and a two-bit mode. The four modes are a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode.

When timer 0 is in split mode, it becomes two independent 8-bit timers. Its high byte counts time-base ticks only. That high byte takes over timer 1's run bit and timer 1's flag. Timer 1 then keeps counting without its run bit. Its rollovers still drive the serial baud pulse, but they no longer set its flag. A timer that is set to split mode itself simply holds its count.

Software loads the count bytes, the run bits and the flags through single-cycle write strobes. The two flags are interrupt requests. Each flag is cleared by a control write or by an acknowledge input.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both counts are zero, both flags are low, `baud_pulse` is low, and the configuration and run bits are zero.
- R2: In timer mode with gate off and the run bit set, a count advances once per time-base tick. The time base is one tick every 6 clocks, and the first tick comes on the 6th clock edge after reset. The counts never change on a clock edge without a tick unless a count write occurs.
- R3: When the gate bit is 1, a running timer advances only while its `gate_pin` bit is high.
- R4: In counter mode, a timer advances once per falling edge of its `evt_in` bit. The edge passes through two synchronizing flops and is detected between consecutive tick samples.
- R5: Mode 0 (mode bits 00) counts on the 13-bit value {high byte, low byte bits 4:0}. Low byte bits 7:5 do not change. The rollover from 0x1FFF sets the flag.
- R6: Mode 1 (mode bits 01) is a 16-bit counter. The rollover from 0xFFFF to 0x0000 sets the flag.
- R7: Mode 2 (mode bits 10) increments only the low byte. When the low byte rolls over from 0xFF, it reloads from the high byte and sets the flag. The high byte does not change.
- R8: With timer 0 in mode 3 (mode bits 11), its low byte is an 8-bit counter under timer 0's gate, select, run bit and flag 0. Its high byte counts ticks only while run bit 1 is set, ignores timer 0's gate and counter select, and sets flag 1 when it rolls over from 0xFF.
- R9: A timer 1 configured to mode 3 holds its count.
- R10: While timer 0 is in mode 3, timer 1 counts regardless of run bit 1, still subject to its own gate and select. Timer 1's rollovers do not set flag 1.
- R11: `baud_pulse` is high for exactly one cycle, in the cycle after each timer 1 rollover, in every configuration.
- R12: A count-byte write loads the selected byte. In that cycle it cancels all counting and overflow of the timer that owns the byte. `cnt_sel` selects the byte: 0 is timer 0 low, 1 is timer 0 high, 2 is timer 1 low, 3 is timer 1 high.
- R13: Flag priority, from highest to lowest, is: a control write, then an overflow set, then an acknowledge clear.
- R14: Configuration layout: bits 3:0 configure timer 0 and bits 7:4 configure timer 1. Within each nibble, bit 3 is the gate, bit 2 selects counter mode, and bits 1:0 are the mode. Control layout: bit 0 is run 0, bit 1 is flag 0, bit 2 is run 1, bit 3 is flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| ctl_we | input | 1 | Control write strobe (run bits and flags) |
| ctl_wdata | input | 4 | Control value |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_sel | input | 2 | Count byte select |
| cnt_wdata | input | 8 | Count byte value |
| evt_in | input | 2 | External event inputs, one per timer |
| gate_pin | input | 2 | Gate qualifier inputs, one per timer |
| irq_ack | input | 2 | Flag acknowledge, one per timer |
| cnt0_q | output | 16 | Timer 0 count {high, low} |
| cnt1_q | output | 16 | Timer 1 count {high, low} |
| irq_flag | output | 2 | Overflow flags (interrupt requests) |
| baud_pulse | output | 1 | One-cycle timer 1 rollover pulse |

## Verification
The bench drives counts to just below each mode's rollover point. A wrong carry boundary in mode 0 would either disturb low byte bits 7:5 or miss the 13-bit wrap. A faulty reload in mode 2 would corrupt the high byte or fail to load the low byte from it. The split phases keep timer 0's gate pin low and pulse its event input, to show that the high half ignores both and answers only to run bit 1. A design that routed timer 1's own overflow into flag 1 during split mode would raise that flag wrongly. Random count writes, acknowledges and control writes land in the same cycle as rollovers, which exposes any design that lets the increment beat the write or puts the acknowledge ahead of the overflow set.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared types for the timer pair: mode encoding and the per-timer
// configuration nibble {gate, counter select, mode}.
package tmr_pkg;
    typedef enum logic [1:0] {
        TM_W13   = 2'd0,
        TM_W16   = 2'd1,
        TM_RLD8  = 2'd2,
        TM_SPLIT = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ctr;
        tmr_mode_e mode;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
// Time-base divider: tick_o is high for one cycle out of every DIV cycles.
// Assumes DIV >= 2. The first tick arrives on the DIV-th edge after reset.
module tmr_tick_gen #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == PW'(DIV - 1));

    // Wrapping prescale counter
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/tmr_evt_sync.sv
`timescale 1ns/1ps
// Event input conditioner: two-flop synchronizer, then a falling-edge
// detector that samples at tick rate. fall_o is only ever high on a tick.
module tmr_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic evt_i,
    output logic fall_o
);
    logic s1_q, s2_q, prev_q;

    assign fall_o = tick_i & prev_q & ~s2_q;

    // Metastability filter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= evt_i;
            s2_q <= s1_q;
        end
    end

    // Tick-rate sample held for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (tick_i) prev_q <= s2_q;
    end
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
// One timer: a low and a high count byte advanced according to the mode.
// A write to either byte cancels the whole unit's counting in that cycle.
// SPLIT_HI=1 makes mode 3 run two 8-bit halves (high half on hi_en_i);
// SPLIT_HI=0 makes mode 3 hold the count.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int BW       = 8,
    parameter int LOW13    = 5,
    parameter bit SPLIT_HI = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_mode_e     mode_i,
    input  logic          en_i,
    input  logic          hi_en_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wr_data_i,
    output logic [BW-1:0] lo_o,
    output logic [BW-1:0] hi_o,
    output logic          ovf_o,
    output logic          hi_ovf_o
);
    localparam int FW = BW + LOW13;

    logic [BW-1:0]   lo_q, hi_q;
    logic [FW-1:0]   v13, v13_nx;
    logic [2*BW-1:0] v16, v16_nx;
    logic            wr;

    assign v13    = {hi_q, lo_q[LOW13-1:0]};
    assign v13_nx = v13 + 1'b1;
    assign v16    = {hi_q, lo_q};
    assign v16_nx = v16 + 1'b1;
    assign wr     = wr_lo_i | wr_hi_i;
    assign lo_o   = lo_q;
    assign hi_o   = hi_q;

    // Rollover detection for the current mode
    always_comb begin
        ovf_o    = 1'b0;
        hi_ovf_o = 1'b0;
        if (!wr) begin
            case (mode_i)
                TM_W13:  ovf_o = en_i & (&v13);
                TM_W16:  ovf_o = en_i & (&v16);
                TM_RLD8: ovf_o = en_i & (&lo_q);
                TM_SPLIT: begin
                    if (SPLIT_HI) begin
                        ovf_o    = en_i & (&lo_q);
                        hi_ovf_o = hi_en_i & (&hi_q);
                    end
                end
                default: ;
            endcase
        end
    end

    // Count bytes: write beats increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr) begin
            if (wr_lo_i) lo_q <= wr_data_i;
            if (wr_hi_i) hi_q <= wr_data_i;
        end else begin
            case (mode_i)
                TM_W13: if (en_i) begin
                    hi_q              <= v13_nx[FW-1:LOW13];
                    lo_q[LOW13-1:0]   <= v13_nx[LOW13-1:0];
                end
                TM_W16: if (en_i) {hi_q, lo_q} <= v16_nx;
                TM_RLD8: if (en_i) lo_q <= (&lo_q) ? hi_q : lo_q + 1'b1;
                TM_SPLIT: begin
                    if (SPLIT_HI) begin
                        if (en_i)    lo_q <= lo_q + 1'b1;
                        if (hi_en_i) hi_q <= hi_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
// Two timer/counters sharing one time base. Holds the configuration byte,
// run bits and flags, routes timer 1's run bit and flag to timer 0's high
// half when timer 0 is split, and registers timer 1 rollovers as the baud
// pulse. Assumes gate_pin is synchronous to clk.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BW       = 8,
    parameter int LOW13    = 5,
    parameter int TICK_DIV = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    input  logic            ctl_we,
    input  logic [3:0]      ctl_wdata,
    input  logic            cnt_we,
    input  logic [1:0]      cnt_sel,
    input  logic [BW-1:0]   cnt_wdata,
    input  logic [1:0]      evt_in,
    input  logic [1:0]      gate_pin,
    input  logic [1:0]      irq_ack,
    output logic [2*BW-1:0] cnt0_q,
    output logic [2*BW-1:0] cnt1_q,
    output logic [1:0]      irq_flag,
    output logic            baud_pulse
);
    localparam int NT = 2;

    logic [7:0]    cfg_q;
    tmr_cfg_t      cfg [NT];
    logic [NT-1:0] run_q, flag_q, fall, run_eff, qual, cnt_en;
    logic [NT-1:0] wr_lo, wr_hi, ovf, hi_ovf, hi_en, flag_set;
    logic [BW-1:0] lo_v [NT];
    logic [BW-1:0] hi_v [NT];
    logic          tick, split, baud_q;

    tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    // Per-timer enables and byte write decode
    always_comb begin
        cfg[0] = tmr_cfg_t'(cfg_q[3:0]);
        cfg[1] = tmr_cfg_t'(cfg_q[7:4]);
        split  = (cfg[0].mode == TM_SPLIT);
        for (int i = 0; i < NT; i++) begin
            run_eff[i] = (i == 1 && split) ? 1'b1 : run_q[i];
            qual[i]    = run_eff[i] & (~cfg[i].gate | gate_pin[i]);
            cnt_en[i]  = qual[i] & (cfg[i].ctr ? fall[i] : tick);
            wr_lo[i]   = cnt_we & (cnt_sel == 2'(2 * i));
            wr_hi[i]   = cnt_we & (cnt_sel == 2'(2 * i + 1));
        end
        hi_en[0] = split & run_q[1] & tick;
        hi_en[1] = 1'b0;
    end

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        tmr_evt_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .evt_i  (evt_in[g]),
            .fall_o (fall[g])
        );

        tmr_unit #(
            .BW       (BW),
            .LOW13    (LOW13),
            .SPLIT_HI (g == 0)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (cfg[g].mode),
            .en_i      (cnt_en[g]),
            .hi_en_i   (hi_en[g]),
            .wr_lo_i   (wr_lo[g]),
            .wr_hi_i   (wr_hi[g]),
            .wr_data_i (cnt_wdata),
            .lo_o      (lo_v[g]),
            .hi_o      (hi_v[g]),
            .ovf_o     (ovf[g]),
            .hi_ovf_o  (hi_ovf[g])
        );
    end

    // Flag sources; timer 1 has no split half, so hi_ovf[1] stays low
    assign flag_set[0] = ovf[0];
    assign flag_set[1] = split ? hi_ovf[0] : (ovf[1] | hi_ovf[1]);

    // Configuration byte
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    // Run bits and flags: write, then overflow set, then acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (ctl_we) begin
                    run_q[i]  <= ctl_wdata[2*i];
                    flag_q[i] <= ctl_wdata[2*i+1];
                end else if (flag_set[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (irq_ack[i]) begin
                    flag_q[i] <= 1'b0;
                end
            end
        end
    end

    // Registered timer 1 rollover for the serial baud generator
    always_ff @(posedge clk) begin
        if (!rst_n) baud_q <= 1'b0;
        else        baud_q <= ovf[1];
    end

    assign cnt0_q     = {hi_v[0], lo_v[0]};
    assign cnt1_q     = {hi_v[1], lo_v[1]};
    assign irq_flag   = flag_q;
    assign baud_pulse = baud_q;
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
// Protocol checks for tmr_pair, attached with bind below.
module tmr_pair_chk #(
    parameter int BW    = 8,
    parameter int LOW13 = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      cfg_q,
    input logic            cnt_we,
    input logic            ctl_we,
    input logic [3:0]      ctl_wdata,
    input logic            tick,
    input logic [1:0]      flag_set,
    input logic [2*BW-1:0] cnt0_q,
    input logic [2*BW-1:0] cnt1_q,
    input logic [1:0]      irq_flag,
    input logic            baud_pulse
);
    AST_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> ($stable(cnt0_q) && $stable(cnt1_q))); // R2
    AST_W13_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1:0] == 2'b00 && !cnt_we) |=> $stable(cnt0_q[BW-1:LOW13])); // R5
    AST_RELOAD_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1:0] == 2'b10 && !cnt_we) |=> $stable(cnt0_q[2*BW-1:BW])); // R7
    AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[5:4] == 2'b11 && !cnt_we) |=> $stable(cnt1_q)); // R9
    AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse |=> !baud_pulse); // R11
    AST_FLAG0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set[0] && !ctl_we) |=> irq_flag[0]); // R13
    AST_FLAG1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set[1] && !ctl_we) |=> irq_flag[1]); // R13
    AST_CTL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (irq_flag == {$past(ctl_wdata[3]), $past(ctl_wdata[1])})); // R13
endmodule

bind tmr_pair tmr_pair_chk #(.BW(BW), .LOW13(LOW13)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_q      (cfg_q),
    .cnt_we     (cnt_we),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .tick       (tick),
    .flag_set   (flag_set),
    .cnt0_q     (cnt0_q),
    .cnt1_q     (cnt1_q),
    .irq_flag   (irq_flag),
    .baud_pulse (baud_pulse)
);

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
// Bench for tmr_pair: directed phases near rollover plus seeded random
// stimulus, compared every cycle against a model built from the requirements.
module test_tmr_pair;
    localparam int DIV = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic        ctl_we;
    logic [3:0]  ctl_wdata;
    logic        cnt_we;
    logic [1:0]  cnt_sel;
    logic [7:0]  cnt_wdata;
    logic [1:0]  evt_in, gate_pin, irq_ack;
    logic [15:0] cnt0_q, cnt1_q;
    logic [1:0]  irq_flag;
    logic        baud_pulse;

    always #2.5 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cnt_we(cnt_we),
        .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata), .evt_in(evt_in),
        .gate_pin(gate_pin), .irq_ack(irq_ack), .cnt0_q(cnt0_q),
        .cnt1_q(cnt1_q), .irq_flag(irq_flag), .baud_pulse(baud_pulse)
    );

    int    total = 0;
    int    fails = 0;
    string cur_req = "R1";

    // Reference state
    int         m_pre;
    logic [1:0] m_s1, m_s2, m_prev, m_run, m_flag;
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [7:0] m_cfg;
    logic       m_baud;

    task automatic model_reset();
        m_pre = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_run = 0; m_flag = 0;
        m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
        m_cfg = 0; m_baud = 0;
    endtask

    // Next reference state from the inputs applied this cycle
    task automatic model_advance();
        logic        tick, split, hiovf0;
        logic [1:0]  fall, en, ovf, set;
        logic [3:0]  c;
        logic [12:0] v13;
        logic [15:0] v16;
        tick   = (m_pre == DIV - 1);
        split  = (m_cfg[1:0] == 2'b11);
        ovf    = 2'b00;
        hiovf0 = 1'b0;
        for (int i = 0; i < 2; i++) begin
            logic re, q;
            c       = (i == 0) ? m_cfg[3:0] : m_cfg[7:4];
            fall[i] = tick && m_prev[i] && !m_s2[i];
            re      = (i == 1 && split) ? 1'b1 : m_run[i];
            q       = re && (!c[3] || gate_pin[i]);
            en[i]   = q && (c[2] ? fall[i] : tick);
            if (cnt_we && (cnt_sel[1] == (i == 1))) begin
                if (cnt_sel[0]) m_hi[i] = cnt_wdata;
                else            m_lo[i] = cnt_wdata;
            end else begin
                case (c[1:0])
                    2'b00: if (en[i]) begin
                        v13 = {m_hi[i], m_lo[i][4:0]};
                        ovf[i] = (v13 == 13'h1FFF);
                        v13 = v13 + 13'd1;
                        m_hi[i] = v13[12:5];
                        m_lo[i][4:0] = v13[4:0];
                    end
                    2'b01: if (en[i]) begin
                        v16 = {m_hi[i], m_lo[i]};
                        ovf[i] = (v16 == 16'hFFFF);
                        v16 = v16 + 16'd1;
                        {m_hi[i], m_lo[i]} = v16;
                    end
                    2'b10: if (en[i]) begin
                        ovf[i] = (m_lo[i] == 8'hFF);
                        m_lo[i] = ovf[i] ? m_hi[i] : m_lo[i] + 8'd1;
                    end
                    default: if (i == 0) begin
                        if (en[i]) begin
                            ovf[i] = (m_lo[i] == 8'hFF);
                            m_lo[i] = m_lo[i] + 8'd1;
                        end
                        if (m_run[1] && tick) begin
                            hiovf0 = (m_hi[i] == 8'hFF);
                            m_hi[i] = m_hi[i] + 8'd1;
                        end
                    end
                endcase
            end
        end
        set[0] = ovf[0];
        set[1] = split ? hiovf0 : ovf[1];
        for (int i = 0; i < 2; i++) begin
            if (ctl_we) begin
                m_run[i]  = ctl_wdata[2*i];
                m_flag[i] = ctl_wdata[2*i+1];
            end else if (set[i]) m_flag[i] = 1'b1;
            else if (irq_ack[i]) m_flag[i] = 1'b0;
        end
        m_baud = ovf[1];
        if (cfg_we) m_cfg = cfg_wdata;
        if (tick) m_prev = m_s2;
        m_s2  = m_s1;
        m_s1  = evt_in;
        m_pre = tick ? 0 : m_pre + 1;
    endtask

    task automatic compare();
        logic [15:0] e0, e1;
        e0 = {m_hi[0], m_lo[0]};
        e1 = {m_hi[1], m_lo[1]};
        total++;
        if (cnt0_q !== e0 || cnt1_q !== e1 || irq_flag !== m_flag || baud_pulse !== m_baud) begin
            fails++;
            $display("FAIL %s t=%0t actual cnt0=%h cnt1=%h flag=%b baud=%b expected cnt0=%h cnt1=%h flag=%b baud=%b",
                     cur_req, $time, cnt0_q, cnt1_q, irq_flag, baud_pulse, e0, e1, m_flag, m_baud);
        end
    endtask

    // One clock: model, edge, then sample at the falling edge
    task automatic adv();
        model_advance();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run_phase(input string req, input logic [7:0] cfg, input logic [3:0] ctl,
                             input logic [1:0] pins, input logic [7:0] l0, input logic [7:0] h0,
                             input logic [7:0] l1, input logic [7:0] h1, input int cycles,
                             input int p_wr, input int p_ack, input int p_ctl,
                             input int p_pin, input int p_evt);
        cur_req  = req;
        gate_pin = pins;
        ctl_we = 1'b1; ctl_wdata = 4'h0; adv(); ctl_we = 1'b0;
        cfg_we = 1'b1; cfg_wdata = cfg;  adv(); cfg_we = 1'b0;
        cnt_we = 1'b1;
        cnt_sel = 2'd0; cnt_wdata = l0; adv();
        cnt_sel = 2'd1; cnt_wdata = h0; adv();
        cnt_sel = 2'd2; cnt_wdata = l1; adv();
        cnt_sel = 2'd3; cnt_wdata = h1; adv();
        cnt_we = 1'b0;
        ctl_we = 1'b1; ctl_wdata = ctl; adv(); ctl_we = 1'b0;
        for (int n = 0; n < cycles; n++) begin
            cnt_we    = ($urandom_range(99) < p_wr);
            cnt_sel   = 2'($urandom);
            cnt_wdata = 8'($urandom);
            irq_ack   = {($urandom_range(99) < p_ack), ($urandom_range(99) < p_ack)};
            ctl_we    = ($urandom_range(99) < p_ctl);
            ctl_wdata = 4'($urandom);
            gate_pin  = gate_pin ^ {($urandom_range(99) < p_pin), ($urandom_range(99) < p_pin)};
            evt_in    = evt_in ^ {($urandom_range(99) < p_evt), ($urandom_range(99) < p_evt)};
            adv();
        end
        cnt_we = 1'b0; ctl_we = 1'b0; irq_ack = 2'b00;
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL %s watchdog expired: actual=running expected=finished", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; ctl_we = 0; ctl_wdata = 0;
        cnt_we = 0; cnt_sel = 0; cnt_wdata = 0; evt_in = 0; gate_pin = 0; irq_ack = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        cur_req = "R1";
        compare();
        adv();
        // R2: plain 16-bit timing on timer 0
        run_phase("R2", 8'h01, 4'h1, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 200, 0, 0, 0, 0, 0);
        // R14: mixed nibbles, timer 1 reload, timer 0 16-bit
        run_phase("R14", 8'h21, 4'h5, 2'b00, 8'h10, 8'h00, 8'hF0, 8'hF0, 600, 0, 0, 0, 0, 0);
        // R3: gated timer 0 with toggling pin
        run_phase("R3", 8'h89, 4'h5, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 3000, 0, 0, 0, 10, 0);
        // R4: event counting on both timers
        run_phase("R4", 8'h55, 4'h5, 2'b00, 8'hF0, 8'hFF, 8'hF8, 8'hFF, 3000, 0, 0, 0, 0, 5);
        // R5: 13-bit wrap, low byte upper bits set
        run_phase("R5", 8'h00, 4'h5, 2'b00, 8'hFC, 8'hFF, 8'hFE, 8'hFF, 400, 0, 0, 0, 0, 0);
        // R6: 16-bit wrap on both
        run_phase("R6", 8'h11, 4'h5, 2'b00, 8'hF0, 8'hFF, 8'hF8, 8'hFF, 300, 0, 0, 0, 0, 0);
        // R7: reload on both
        run_phase("R7", 8'h22, 4'h5, 2'b00, 8'hFE, 8'hF0, 8'hFC, 8'h80, 3000, 0, 0, 0, 0, 0);
        // R8: split with gate on and pin low: high half must still count
        run_phase("R8", 8'h0F, 4'h5, 2'b00, 8'hF8, 8'hF0, 8'h00, 8'h00, 4000, 0, 0, 0, 0, 5);
        // R9: timer 1 in mode 3 holds
        run_phase("R9", 8'h31, 4'h5, 2'b11, 8'h00, 8'h00, 8'h55, 8'hAA, 500, 0, 0, 0, 0, 0);
        // R10: timer 1 runs with run bit 1 clear while timer 0 split
        run_phase("R10", 8'h23, 4'h1, 2'b00, 8'h00, 8'h00, 8'hF0, 8'hF0, 3000, 0, 0, 0, 0, 0);
        // R11: fast baud pulses
        run_phase("R11", 8'h20, 4'h4, 2'b00, 8'h00, 8'h00, 8'hFD, 8'hFD, 2000, 0, 0, 0, 0, 0);
        // R12: count writes colliding with increments
        run_phase("R12", 8'h11, 4'h5, 2'b00, 8'hF0, 8'hFF, 8'hF0, 8'hFF, 3000, 20, 0, 0, 0, 0);
        // R13: acknowledges and control writes against overflow sets
        run_phase("R13", 8'h22, 4'h5, 2'b00, 8'hFE, 8'hFE, 8'hFE, 8'hFE, 3000, 0, 20, 5, 0, 0);
        // Mixed random configurations
        for (int k = 0; k < 20; k++) begin
            run_phase("R14", 8'($urandom), 4'($urandom), 2'($urandom), 8'($urandom),
                      8'($urandom), 8'($urandom), 8'($urandom), 2000, 3, 5, 1, 5, 5);
        end
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end
endmodule